// File: doc/BRIEF.md
# Multi-Bus Interrupt Register Front End

This block is the register front end of a controller that serves a set of identical two-wire serial bus channels (fourteen by default). A 4 KB register window is split into a global area and one 64-byte window per bus channel. Every channel keeps a function-control word, two timing words, an interrupt-enable mask, an interrupt-status word, a command word and a byte buffer, each with its own writable-bit mask. The bus sequencers are not part of this block. Each channel reports events to it as one-cycle status pulses.

When a channel raises events, its status is merged with the new bits and then filtered by that channel's enable mask. A channel whose filtered status is nonzero sets its bit in a global pending vector, and one interrupt line is driven high while any pending bit is set. Software acknowledges a channel by writing ones to its status word. This clears the written status bits and that channel's pending bit.

The channel windows are not contiguous. The first seven channels sit right after the global area. A four-window buffer-pool hole then pushes the remaining channels further up the map. The pool ranges and every other address that is not decoded read back as all ones, and writes to them do nothing. Requests use a simple valid/write/address/data port, and read data is registered one cycle later.

Top module: `mbus_intr_front`

## Requirements
- R1: Channel i (0-based) is decoded at byte address 0x40*(i+1) for i<7 and at 0x40*(i+5) for i>=7. Inside a window, the registers are at these offsets: control 0x00, timing-A 0x04, timing-B 0x08, enable 0x0C, status 0x10, command 0x14, byte buffer 0x20.
- R2: A read of any undecoded address returns 0xFFFFFFFF, and a write to one changes no register. Undecoded addresses are:
  - the global area apart from 0x000;
  - the pools 0x200-0x2FF and 0x800-0xFFF;
  - the range 0x4C0-0x7FF;
  - window offsets 0x18, 0x1C and 0x24-0x3C;
  - any address whose two low bits are not zero.
- R3: Writes keep only these bits: control & 0x0071C3FF, timing-A & 0x0FFFFF0F, timing-B & 0x7, enable & 0x7FFF, command bits [15:0], buffer bits [7:0]. The remaining bits read as zero.
- R4: A control write whose bit 1 is one is discarded, and the control word keeps its old value.
- R5: A command write is discarded unless bit 0 of that channel's control word is one.
- R6: Event bits for channel b arrive in evt_in[15*b+14 : 15*b], and bit k maps to status bit k. In a cycle with any nonzero event bit, the new status is (old status after any clear | events) & enable. This drops old bits that are no longer enabled. If the result is nonzero, pending bit b is set, and irq_out is high after that same clock edge.
- R7: An event whose filtered status is zero sets no pending bit.
- R8: A write to a channel's status word clears the status bits written as one (bits [14:0]) and clears that channel's pending bit. A nonzero filtered event in the same cycle is merged after the clear and sets the pending bit again.
- R9: Address 0x000 reads the pending vector in bits [13:0], with zeros above. Writes to it are ignored.
- R10: irq_out is high exactly while any pending bit is set. Acknowledging one channel leaves it high if another channel is still pending.
- R11: Reset clears every register, the pending vector, irq_out and rsp_rdata.
- R12: Read data appears on rsp_rdata in the cycle after the read request, and it holds there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the 4 KB window |
| req_wdata | input | 32 | Write data |
| evt_in | input | 210 | Per-channel event pulses, 15 bits per channel |
| rsp_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The hardest situation to reach from the ports is a status acknowledge and a fresh event hitting the same channel in the same clock cycle. The bench drives the status write and the event pulse in the same cycle and expects the new bit to survive with the interrupt still raised. Reaching the second-tier channels requires the exact address jump over the pool hole, so the stimulus table hits the first channel past the hole and the last channel, and also probes the hole itself. It also shows that an event filtered down to zero leaves the pending vector untouched, and that clearing one channel keeps the line high while another is still pending.

// File: rtl/mbif_pkg.sv
package mbif_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_TIMA = 3'd1,
      SEL_TIMB = 3'd2,
      SEL_IEN  = 3'd3,
      SEL_ISTS = 3'd4,
      SEL_CMD  = 3'd5,
      SEL_BUF  = 3'd6,
      SEL_NONE = 3'd7
   } reg_sel_e;

   localparam logic [31:0] CTRL_KEEP = 32'h0071_C3FF;
   localparam logic [31:0] TIMA_KEEP = 32'h0FFF_FF0F;
   localparam logic [31:0] TIMB_KEEP = 32'h0000_0007;
   localparam int          CMD_BITS  = 16;
   localparam int          BUF_BITS  = 8;
   localparam int          WIN_BYTES = 64;

endpackage

// File: rtl/mbif_decode.sv
module mbif_decode
   import mbif_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NUM_BUSES  = 14,
   parameter int LOW_BUSES  = 7,
   parameter int HOLE_WINS  = 4,
   localparam int WIN_SH    = $clog2(WIN_BYTES),
   localparam int WIN_W     = ADDR_W - WIN_SH,
   localparam int IDX_W     = $clog2(NUM_BUSES)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_glob_stat,
   output logic              hit_bus,
   output logic [IDX_W-1:0]  bus_idx,
   output reg_sel_e          sel
);
   localparam logic [WIN_W-1:0] LO_LAST  = WIN_W'(LOW_BUSES);
   localparam logic [WIN_W-1:0] HI_FIRST = WIN_W'(LOW_BUSES + 1 + HOLE_WINS);
   localparam logic [WIN_W-1:0] HI_LAST  = WIN_W'(NUM_BUSES + HOLE_WINS);

   logic [WIN_W-1:0] win;
   logic [3:0]       word;
   logic             aligned;
   logic             in_lo, in_hi;

   assign win     = addr[ADDR_W-1:WIN_SH];
   assign word    = addr[WIN_SH-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign in_lo   = (win != '0) && (win <= LO_LAST);
   assign in_hi   = (win >= HI_FIRST) && (win <= HI_LAST);

   assign hit_glob_stat = aligned && (win == '0) && (word == 4'd0);
   assign hit_bus       = aligned && (in_lo || in_hi);

   always_comb begin
      if (in_hi) bus_idx = IDX_W'(win - WIN_W'(HOLE_WINS + 1));
      else       bus_idx = IDX_W'(win - WIN_W'(1));
   end

   always_comb begin
      unique case (word)
         4'd0:    sel = SEL_CTRL;
         4'd1:    sel = SEL_TIMA;
         4'd2:    sel = SEL_TIMB;
         4'd3:    sel = SEL_IEN;
         4'd4:    sel = SEL_ISTS;
         4'd5:    sel = SEL_CMD;
         4'd8:    sel = SEL_BUF;
         default: sel = SEL_NONE;
      endcase
   end

   // R1: a channel window and the global status word never both decode
   always_comb begin
      a_r1_decode_exclusive: assert (!(hit_bus && hit_glob_stat));
   end
endmodule

// File: rtl/mbif_bus_regs.sv
module mbif_bus_regs
   import mbif_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STAT_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STAT_W-1:0] evt,
   output logic [DATA_W-1:0] rdata,
   output logic              pending
);
   logic [DATA_W-1:0]   ctrl_q, tima_q, timb_q;
   logic [STAT_W-1:0]   ien_q, ists_q;
   logic [CMD_BITS-1:0] cmd_q;
   logic [BUF_BITS-1:0] buf_q;

   logic                ack;
   logic [STAT_W-1:0]   clr, kept, merged, ists_d;
   logic                raise, pend_d;

   assign ack    = wr_en && (sel == SEL_ISTS);
   assign clr    = ack ? wdata[STAT_W-1:0] : '0;
   assign kept   = ists_q & ~clr;
   assign raise  = |evt;
   assign merged = (kept | evt) & ien_q;
   assign ists_d = raise ? merged : kept;

   always_comb begin
      if (raise && (|merged)) pend_d = 1'b1;
      else if (ack)           pend_d = 1'b0;
      else                    pend_d = pending;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         tima_q  <= '0;
         timb_q  <= '0;
         ien_q   <= '0;
         ists_q  <= '0;
         cmd_q   <= '0;
         buf_q   <= '0;
         pending <= 1'b0;
      end else begin
         ists_q  <= ists_d;
         pending <= pend_d;
         if (wr_en) begin
            unique case (sel)
               SEL_CTRL: if (!wdata[1]) ctrl_q <= wdata & DATA_W'(CTRL_KEEP);
               SEL_TIMA: tima_q <= wdata & DATA_W'(TIMA_KEEP);
               SEL_TIMB: timb_q <= wdata & DATA_W'(TIMB_KEEP);
               SEL_IEN:  ien_q  <= wdata[STAT_W-1:0];
               SEL_CMD:  if (ctrl_q[0]) cmd_q <= wdata[CMD_BITS-1:0];
               SEL_BUF:  buf_q  <= wdata[BUF_BITS-1:0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL: rdata = ctrl_q;
         SEL_TIMA: rdata = tima_q;
         SEL_TIMB: rdata = timb_q;
         SEL_IEN:  rdata = DATA_W'(ien_q);
         SEL_ISTS: rdata = DATA_W'(ists_q);
         SEL_CMD:  rdata = DATA_W'(cmd_q);
         SEL_BUF:  rdata = DATA_W'(buf_q);
         default:  rdata = '1;
      endcase
   end

   a_r4_slave_bit_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CTRL && wdata[1]) |=> $stable(ctrl_q));

   a_r5_cmd_locked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CMD && !ctrl_q[0]) |=> $stable(cmd_q));

   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !raise) |=> (((ists_q & $past(wdata[STAT_W-1:0])) == '0) && !pending));

   a_r7_pending_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> (ists_q != '0));
endmodule

// File: rtl/mbus_intr_front.sv
module mbus_intr_front
   import mbif_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NUM_BUSES = 14,
   parameter int LOW_BUSES = 7,
   parameter int HOLE_WINS = 4,
   parameter int STAT_W    = 15,
   localparam int IDX_W    = $clog2(NUM_BUSES),
   localparam int EVT_W    = NUM_BUSES * STAT_W,
   localparam int POOL_WIN = (2 ** (ADDR_W - $clog2(WIN_BYTES))) / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [EVT_W-1:0]  evt_in,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              irq_out
);
   if (DATA_W != 32) begin : g_bad_data_w
      $error("mbus_intr_front: register masks assume a 32-bit data path");
   end
   if (NUM_BUSES + HOLE_WINS + 1 > POOL_WIN) begin : g_bad_map
      $error("mbus_intr_front: channel windows overrun the upper pool");
   end
   if (NUM_BUSES > DATA_W || STAT_W > DATA_W || LOW_BUSES > NUM_BUSES) begin : g_bad_counts
      $error("mbus_intr_front: channel or status count out of range");
   end

   logic             hit_glob_stat, hit_bus;
   logic [IDX_W-1:0] dec_idx;
   reg_sel_e         dec_sel;

   mbif_decode #(
      .ADDR_W(ADDR_W), .NUM_BUSES(NUM_BUSES),
      .LOW_BUSES(LOW_BUSES), .HOLE_WINS(HOLE_WINS)
   ) u_decode (
      .addr(req_addr), .hit_glob_stat(hit_glob_stat), .hit_bus(hit_bus),
      .bus_idx(dec_idx), .sel(dec_sel)
   );

   logic [DATA_W-1:0]    bus_rd [NUM_BUSES];
   logic [NUM_BUSES-1:0] pend;

   for (genvar b = 0; b < NUM_BUSES; b++) begin : g_bus
      logic wr_this;
      assign wr_this = req_valid && req_write && hit_bus && (dec_idx == IDX_W'(b));
      mbif_bus_regs #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_regs (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_this), .sel(dec_sel),
         .wdata(req_wdata), .evt(evt_in[b*STAT_W +: STAT_W]),
         .rdata(bus_rd[b]), .pending(pend[b])
      );
   end

   logic [DATA_W-1:0] rd_bus, rd_next;

   always_comb begin
      rd_bus = '1;
      for (int b = 0; b < NUM_BUSES; b++) begin
         if (dec_idx == IDX_W'(b)) rd_bus = bus_rd[b];
      end
   end

   always_comb begin
      if (hit_glob_stat) rd_next = DATA_W'(pend);
      else if (hit_bus)  rd_next = rd_bus;
      else               rd_next = '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       rsp_rdata <= '0;
      else if (req_valid && !req_write) rsp_rdata <= rd_next;
   end

   assign irq_out = |pend;

   a_r10_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(|evt_in));

   a_r9_global_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && hit_glob_stat && !(|evt_in)) |=> $stable(pend));

   a_r12_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> $stable(rsp_rdata));
endmodule

// File: tb/test_mbus_intr_front.sv
module test_mbus_intr_front;
   localparam int NB = 14;
   localparam int SW = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [11:0]   req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [NB*SW-1:0] evt_in = '0;
   logic [31:0]   rsp_rdata;
   logic          irq_out;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mbus_intr_front i_mbus_intr_front (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .evt_in(evt_in),
      .rsp_rdata(rsp_rdata), .irq_out(irq_out)
   );

   typedef struct packed {
      logic        wr;
      logic [11:0] a;
      logic [31:0] d;
      logic [31:0] e;
      logic [3:0]  r;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VT [NV] = '{
      '{1'b1, 12'h044, 32'hFFFF_FFFF, 32'h0,          4'd3},  // R3
      '{1'b0, 12'h044, 32'h0,         32'h0FFF_FF0F,  4'd3},  // R3 timing-A mask
      '{1'b1, 12'h048, 32'hFFFF_FFFF, 32'h0,          4'd3},
      '{1'b0, 12'h048, 32'h0,         32'h0000_0007,  4'd3},  // R3 timing-B mask
      '{1'b1, 12'h04C, 32'hFFFF_FFFF, 32'h0,          4'd3},
      '{1'b0, 12'h04C, 32'h0,         32'h0000_7FFF,  4'd3},  // R3 enable mask
      '{1'b1, 12'h040, 32'hFFFF_FFFD, 32'h0,          4'd3},
      '{1'b0, 12'h040, 32'h0,         32'h0071_C3FD,  4'd3},  // R3 control mask
      '{1'b1, 12'h040, 32'h0000_0002, 32'h0,          4'd4},
      '{1'b0, 12'h040, 32'h0,         32'h0071_C3FD,  4'd4},  // R4 dropped
      '{1'b1, 12'h060, 32'h0000_1234, 32'h0,          4'd3},
      '{1'b0, 12'h060, 32'h0,         32'h0000_0034,  4'd3},  // R3 buffer
      '{1'b1, 12'h054, 32'h000A_BCDE, 32'h0,          4'd5},
      '{1'b0, 12'h054, 32'h0,         32'h0000_BCDE,  4'd5},  // R5 enabled
      '{1'b1, 12'h094, 32'h0000_0001, 32'h0,          4'd5},
      '{1'b0, 12'h094, 32'h0,         32'h0000_0000,  4'd5},  // R5 locked
      '{1'b1, 12'h1CC, 32'h0000_0055, 32'h0,          4'd1},
      '{1'b0, 12'h1CC, 32'h0,         32'h0000_0055,  4'd1},  // R1 channel 6
      '{1'b1, 12'h304, 32'h0000_0123, 32'h0,          4'd1},
      '{1'b0, 12'h304, 32'h0,         32'h0000_0103,  4'd1},  // R1 channel 7
      '{1'b1, 12'h48C, 32'h0000_0007, 32'h0,          4'd1},
      '{1'b0, 12'h48C, 32'h0,         32'h0000_0007,  4'd1},  // R1 channel 13
      '{1'b0, 12'h058, 32'h0,         32'hFFFF_FFFF,  4'd2},  // R2 offset 0x18
      '{1'b0, 12'h004, 32'h0,         32'hFFFF_FFFF,  4'd2},  // R2 global area
      '{1'b1, 12'h208, 32'h0000_FFFF, 32'h0,          4'd2},
      '{1'b0, 12'h208, 32'h0,         32'hFFFF_FFFF,  4'd2},  // R2 low pool
      '{1'b0, 12'h4C0, 32'h0,         32'hFFFF_FFFF,  4'd2},  // R2 past last
      '{1'b0, 12'h800, 32'h0,         32'hFFFF_FFFF,  4'd2},  // R2 high pool
      '{1'b1, 12'h05C, 32'h0000_0001, 32'h0,          4'd2},
      '{1'b0, 12'h05C, 32'h0,         32'hFFFF_FFFF,  4'd2},  // R2 offset 0x1C
      '{1'b0, 12'h000, 32'h0,         32'h0000_0000,  4'd9},  // R9 idle
      '{1'b0, 12'h2C4, 32'h0,         32'hFFFF_FFFF,  4'd2}   // R2 hole window
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = rsp_rdata;
   endtask

   task automatic ev(input int b, input logic [SW-1:0] bits);
      @(negedge clk);
      evt_in[b*SW +: SW] = bits;
      @(negedge clk);
      evt_in = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 rdata", rsp_rdata, 32'h0);
      chk("R11 irq", {31'h0, irq_out}, 32'h0);
      rd(12'h040, d); chk("R11 control", d, 32'h0);
      rd(12'h04C, d); chk("R11 enable", d, 32'h0);
      rd(12'h000, d); chk("R11 pending", d, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VT[i].wr) wr(VT[i].a, VT[i].d);
         else begin
            rd(VT[i].a, d);
            chk($sformatf("R%0d vector %0d", VT[i].r, i), d, VT[i].e);
         end
      end

      // R6 event on channel 0 (enable 0x7FFF)
      ev(0, 15'h0005);
      chk("R6 irq", {31'h0, irq_out}, 32'h1);
      rd(12'h050, d); chk("R6 status", d, 32'h5);
      rd(12'h000, d); chk("R9 pending ch0", d, 32'h1);
      // R7 filtered-out event on channel 13 (enable 0x7)
      ev(13, 15'h0008);
      rd(12'h490, d); chk("R7 status", d, 32'h0);
      rd(12'h000, d); chk("R7 pending", d, 32'h1);
      ev(13, 15'h0002);
      rd(12'h000, d); chk("R6 pending two", d, 32'h2001);
      // R8 / R10 acknowledge one channel
      wr(12'h050, 32'h1);
      rd(12'h050, d); chk("R8 status", d, 32'h4);
      rd(12'h000, d); chk("R8 pending", d, 32'h2000);
      chk("R10 irq held", {31'h0, irq_out}, 32'h1);
      // R9 global write ignored
      wr(12'h000, 32'hFFFF_FFFF);
      rd(12'h000, d); chk("R9 write ignored", d, 32'h2000);
      wr(12'h490, 32'h2);
      rd(12'h000, d); chk("R10 pending empty", d, 32'h0);
      chk("R10 irq low", {31'h0, irq_out}, 32'h0);
      // R8 acknowledge and event in the same cycle
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h050; req_wdata = 32'h4;
      evt_in[0 +: SW] = 15'h0001;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; evt_in = '0;
      chk("R8 same-cycle irq", {31'h0, irq_out}, 32'h1);
      rd(12'h050, d); chk("R8 same-cycle status", d, 32'h1);
      // R12 hold
      repeat (3) @(negedge clk);
      chk("R12 rdata held", rsp_rdata, 32'h1);
      // R6 enable filter drops old bits
      wr(12'h04C, 32'h2);
      ev(0, 15'h0004);
      rd(12'h050, d); chk("R6 filtered status", d, 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule